// File: doc/BRIEF.md
# Parallel Flash Command-Cycle Capture

This block sits behind the asynchronous pins of a flash-style parallel bus. It turns command-write cycles into clean, single-cycle events in the system clock domain. A fast system clock oversamples the chip-enable, write-enable, output-enable and address-valid strobes through a synchronizer chain. The address and data buses pass through a matching pipeline, so every bus sample lines up with the strobe sample it belongs to. A write is recognised when write-enable and chip-enable are both low. Either of the two may be the one that pulses, as long as output-enable stays high. The write closes at the first of the two to rise.

At the close, the captured address and data appear on `cmd_addr`/`cmd_data` together with a one-cycle `cmd_valid` pulse for a downstream command decoder.

- **Address source:** if address-valid was pulsed low during the chip-enable session, the address is the one held from its rising edge. Otherwise the address comes from the bus at the closing edge.
- **Output-enable low:** a write seen while output-enable is low is dropped, and a one-cycle `proto_err` is raised instead.
- **Read path:** the address register follows the bus while chip-enable and address-valid are both low, and holds from the address-valid rise.
- **Data drivers:** a direct enable for the data-bus drivers is produced from the raw pins, so the drivers float at once when chip-enable or output-enable goes high.

The command output is a valid-only stream with no back-pressure. Write cycles are far longer than a system clock, so the decoder must accept every pulse in the cycle it appears. The bus must stay stable for one system clock after the closing strobe edge. The system clock must run at least four times faster than the shortest strobe pulse.

Top module: `flash_cmd_capture`

## Requirements
- R1: After reset `cmd_valid` and `proto_err` are low and `rd_addr` is zero, and no command appears until a write cycle closes (read mode).
- R2: With chip-enable held low and output-enable high, a write-enable low pulse produces one `cmd_valid` pulse carrying the bus address and data. The pulse is high in the third system clock edge after the edge-aligned rise of write-enable.
- R3: With write-enable held low and output-enable high, a chip-enable low pulse produces one `cmd_valid` pulse with the same timing and contents as R2.
- R4: When address-valid is pulsed low and released while chip-enable is low, the command address is the bus value held at that release. Later bus address changes before the closing edge do not alter it.
- R5: Without an address-valid pulse, the command address is the bus value at the closing strobe edge, not the value present when the strobe fell.
- R6: When write-enable and chip-enable are both low, data is taken at whichever rises first. The later rise of the other strobe produces no second command.
- R7: A write cycle during which output-enable is low produces no `cmd_valid`. Instead `proto_err` is high for exactly one cycle, in the cycle the command would have appeared.
- R8: `dq_oe` is high exactly when `ce_n` and `oe_n` are both low, with no clock delay.
- R9: While chip-enable and address-valid are both low, `rd_addr` follows the bus address with a three-clock delay. After address-valid rises, `rd_addr` holds its value while the bus changes.
- R10: `cmd_valid` is never high in two consecutive cycles.
- R11: An address-valid capture is used by one write only. It is also discarded when chip-enable goes high, so the next write without an address-valid pulse takes its address from the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x faster than the shortest strobe pulse |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| avd_n | input | 1 | Address-valid strobe, active low, asynchronous |
| addr | input | AW | Bus address |
| dq_in | input | DW | Data bus as seen at the input buffers |
| dq_oe | output | 1 | Data-bus driver enable (high = drive) |
| cmd_valid | output | 1 | One-cycle pulse: captured command available |
| cmd_addr | output | AW | Captured command address |
| cmd_data | output | DW | Captured command data |
| proto_err | output | 1 | One-cycle pulse: write seen with output-enable low |
| rd_addr | output | AW | Read address, tracked and held by address-valid |

## Verification
Each result has a fixed latency from the system clock edge that first sees a pin change:

| Result | When it is due |
|---|---|
| `cmd_valid` or `proto_err` | Rises after the third rising edge following a strobe change made at a falling edge (two synchronizer stages plus the output register), and is gone one edge later |
| `rd_addr` | Shows a new bus address after the third edge |
| `dq_oe` | Changes within the same half cycle as the pins |

The checks drive every pin at falling edges and sample one nanosecond after rising edges. For `cmd_valid` and `proto_err`, each check confirms the output is still low after the second edge, high after the third and low again after the fourth. This pins the latency exactly rather than waiting for a pulse.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  // Strobe set as seen on the pins; all active low.
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic avd_n;
  } fcc_strb_t;

  localparam fcc_strb_t STRB_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, avd_n: 1'b1};

  // A write strobe is open while both chip-enable and write-enable are low.
  function automatic logic wr_open(fcc_strb_t s);
    return !s.ce_n && !s.we_n;
  endfunction

endpackage

// File: rtl/fcc_sync.sv
module fcc_sync #(
  parameter int unsigned      W       = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fcc_avd_latch.sv
module fcc_avd_latch
  import fcc_pkg::*;
#(
  parameter int unsigned AW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fcc_strb_t     strb,
  input  fcc_strb_t     strb_q,
  input  logic [AW-1:0] bus_addr,
  input  logic          wr_end,
  output logic [AW-1:0] rd_addr,
  output logic          avd_seen
);

  logic avd_rise;
  logic pass_open;

  assign avd_rise  = strb.avd_n && !strb_q.avd_n && !strb.ce_n;
  assign pass_open = !strb.ce_n && !strb.avd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr  <= '0;
      avd_seen <= 1'b0;
    end else begin
      if (pass_open) rd_addr <= bus_addr;
      if (strb.ce_n || wr_end) avd_seen <= 1'b0;
      else if (avd_rise)       avd_seen <= 1'b1;
    end
  end

  // R9: address-valid high or chip-enable high freezes the read address.
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.avd_n || strb.ce_n) |=> $stable(rd_addr));

  // R11: a chip-enable-high cycle leaves no address-valid capture behind.
  p_seen_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ce_n |=> !avd_seen);

endmodule

// File: rtl/fcc_write_capture.sv
module fcc_write_capture
  import fcc_pkg::*;
#(
  parameter int unsigned AW = 23,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fcc_strb_t     strb,
  input  fcc_strb_t     strb_q,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          avd_seen,
  input  logic [AW-1:0] avd_addr,
  output logic          wr_end,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          proto_err
);

  logic open_now, open_prev, close, viol, bad;

  assign open_now  = wr_open(strb);
  assign open_prev = wr_open(strb_q);
  assign close     = open_prev && !open_now;
  assign bad       = viol || !strb.oe_n;
  assign wr_end    = close;

  // Remember any output-enable-low sample inside an open write strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      viol <= 1'b0;
    else if (close)                  viol <= 1'b0;
    else if (open_now && !strb.oe_n) viol <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      proto_err <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= close && !bad;
      proto_err <= close && bad;
      if (close && !bad) begin
        cmd_addr <= avd_seen ? avd_addr : bus_addr;
        cmd_data <= bus_data;
      end
    end
  end

  // R2: a command only follows a cycle that sampled output-enable high.
  p_cmd_oe_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(strb.oe_n));

  // R7: an error pulse only follows a cycle in which the strobe was closed.
  p_err_after_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !$past(open_now));

endmodule

// File: rtl/flash_cmd_capture.sv
module flash_cmd_capture
  import fcc_pkg::*;
#(
  parameter int unsigned AW          = 23,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          avd_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic          dq_oe,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          proto_err,
  output logic [AW-1:0] rd_addr
);

  localparam int unsigned STRB_W = $bits(fcc_strb_t);
  localparam int unsigned BUS_W  = AW + DW;

  fcc_strb_t         strb_raw, strb, strb_q;
  logic [STRB_W-1:0] strb_vec;
  logic [BUS_W-1:0]  bus_vec;
  logic [AW-1:0]     bus_addr;
  logic [DW-1:0]     bus_data;
  logic              avd_seen, wr_end;

  assign strb_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, avd_n: avd_n};

  // Strobes and bus go through chains of equal depth so samples stay aligned.
  fcc_sync #(.W(STRB_W), .STAGES(SYNC_STAGES), .RST_VAL(STRB_IDLE)) u_sync_strb (
    .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_vec)
  );
  fcc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(bus_vec)
  );

  assign strb                 = fcc_strb_t'(strb_vec);
  assign {bus_addr, bus_data} = bus_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= STRB_IDLE;
    else        strb_q <= strb;
  end

  fcc_avd_latch #(.AW(AW)) u_avd (
    .clk(clk), .rst_n(rst_n), .strb(strb), .strb_q(strb_q),
    .bus_addr(bus_addr), .wr_end(wr_end),
    .rd_addr(rd_addr), .avd_seen(avd_seen)
  );

  fcc_write_capture #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .strb(strb), .strb_q(strb_q),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .avd_seen(avd_seen), .avd_addr(rd_addr), .wr_end(wr_end),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .proto_err(proto_err)
  );

  // Driver enable straight from the pins: floats without synchronizer delay.
  assign dq_oe = !ce_n && !oe_n;

  // R10: a command pulse never lasts two cycles.
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R7: a write is either accepted or flagged, never both.
  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && proto_err));

  // R7: the error flag is a single-cycle pulse.
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);

endmodule

// File: tb/test_flash_cmd_capture.sv
`timescale 1ns/100ps
module test_flash_cmd_capture;

  localparam int AW = 23;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, avd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic dq_oe, cmd_valid, proto_err;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [DW-1:0] cmd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  flash_cmd_capture #(.AW(AW), .DW(DW)) i_flash_cmd_capture (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .avd_n(avd_n), .addr(addr), .dq_in(dq_in), .dq_oe(dq_oe),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .proto_err(proto_err), .rd_addr(rd_addr)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Called right after a strobe rise made at a falling edge.
  task automatic expect_close(string req, logic err, logic [AW-1:0] ea, logic [DW-1:0] ed);
    @(posedge clk); @(posedge clk); #1;
    chk(req, "cmd_valid early", cmd_valid, 0);
    chk(req, "proto_err early", proto_err, 0);
    @(posedge clk); #1;
    chk(req, "cmd_valid", cmd_valid, !err);
    chk(req, "proto_err", proto_err, err);
    if (!err) begin
      chk(req, "cmd_addr", cmd_addr, ea);
      chk(req, "cmd_data", cmd_data, ed);
    end
    @(posedge clk); #1;
    chk({req, " R10"}, "cmd_valid drop", cmd_valid, 0);
    chk(req, "proto_err drop", proto_err, 0);
    @(negedge clk);
  endtask

  task automatic expect_quiet(string req, int n);
    repeat (n) begin
      @(posedge clk); #1;
      chk(req, "no cmd", cmd_valid, 0);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "cmd_valid", cmd_valid, 0);
    chk("R1", "proto_err", proto_err, 0);
    chk("R1", "rd_addr", rd_addr, 0);
    cyc(2); rst_n = 1'b1;
    expect_quiet("R1", 6);
  endtask

  // R2 + R5: write-enable controlled, address moves while the strobe is low.
  task automatic t_we_write;
    ce_n = 0; addr = 23'h12345; dq_in = 16'h00AA; cyc(2);
    we_n = 0; cyc(3);
    addr = 23'h54321; cyc(2);
    we_n = 1;
    expect_close("R2 R5", 0, 23'h54321, 16'h00AA);
    ce_n = 1; cyc(3);
  endtask

  task automatic t_ce_write;
    we_n = 0; addr = 23'h00555; dq_in = 16'h0055; cyc(2);
    ce_n = 0; cyc(4);
    ce_n = 1;
    expect_close("R3", 0, 23'h00555, 16'h0055);
    we_n = 1; cyc(3);
  endtask

  task automatic t_avd_write;
    ce_n = 0; addr = 23'h0AAAA; avd_n = 0; cyc(3);
    avd_n = 1; cyc(1);
    addr = 23'h01111; dq_in = 16'h00F0; cyc(1);
    we_n = 0; cyc(3); we_n = 1;
    expect_close("R4", 0, 23'h0AAAA, 16'h00F0);
    // Second write in the same session, no address-valid pulse.
    addr = 23'h02222; dq_in = 16'h0090; cyc(1);
    we_n = 0; cyc(3); we_n = 1;
    expect_close("R11 reuse", 0, 23'h02222, 16'h0090);
    // Capture, then chip-enable high discards it.
    addr = 23'h03333; avd_n = 0; cyc(3); avd_n = 1; cyc(2);
    ce_n = 1; cyc(3);
    ce_n = 0; addr = 23'h04444; dq_in = 16'h0011; cyc(2);
    we_n = 0; cyc(3); we_n = 1;
    expect_close("R11 ce_high", 0, 23'h04444, 16'h0011);
    ce_n = 1; cyc(3);
  endtask

  task automatic t_first_edge;
    ce_n = 0; addr = 23'h00777; dq_in = 16'h1234; cyc(2);
    we_n = 0; cyc(3);
    we_n = 1;
    expect_close("R6", 0, 23'h00777, 16'h1234);
    dq_in = 16'h9999; cyc(2);
    we_n = 0; ce_n = 1; cyc(1); we_n = 1; // close strobe differently: both high
    expect_quiet("R6", 6);
  endtask

  task automatic t_oe_low;
    ce_n = 0; oe_n = 0; #1;
    chk("R8", "dq_oe on", dq_oe, 1);
    addr = 23'h00321; dq_in = 16'h4321; cyc(2);
    we_n = 0; cyc(3); we_n = 1;
    expect_close("R7", 1, '0, '0);
    oe_n = 1; #1;
    chk("R8", "dq_oe oe high", dq_oe, 0);
    oe_n = 0; ce_n = 1; #1;
    chk("R8", "dq_oe ce high", dq_oe, 0);
    oe_n = 1;
    cyc(3);
  endtask

  task automatic t_read_track;
    ce_n = 0; avd_n = 0; addr = 23'h06060; cyc(4);
    chk("R9", "rd_addr track 1", rd_addr, 23'h06060);
    addr = 23'h07070; cyc(4);
    chk("R9", "rd_addr track 2", rd_addr, 23'h07070);
    avd_n = 1; cyc(1);
    addr = 23'h08080; cyc(4);
    chk("R9", "rd_addr hold", rd_addr, 23'h07070);
    ce_n = 1; cyc(3);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_we_write();
    t_ce_write();
    t_avd_write();
    t_first_edge();
    t_oe_low();
    t_read_track();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule